// File: doc/BRIEF.md
# Min-Select Variable Node Accumulator

This block is the arithmetic core of one variable node in a layered min-sum decoder. It keeps two signed registers for a single code bit. One holds the a priori value. The other is a running accumulator. The edges attached to the node are handled one per clock cycle. For each edge, a check node supplies the product of its incoming signs and its two smallest magnitudes. The node also supplies the message it last sent to that check node. From these inputs the block recovers the check-to-variable contribution that belongs to this edge alone.

An external sequencer drives a 3-bit operation code. Operations 0 and 5 to 7 hold all state. Load (1) writes an extrinsic value into both registers, as happens at a super-iteration boundary. Restart (2) reloads the accumulator from the stored a priori value at the start of a local pass. Accumulate (3) adds the edge's signed contribution into the accumulator. Emit (4) produces the new outgoing message for an edge as the accumulated total minus that edge's own contribution. The message is given in sign-magnitude form. The hard decision is always taken from the sign of the accumulator.

Top module: `vnode_min_accum`

## Requirements
- R1: While reset is low, and after it is released, the accumulator and a priori register are 0, `hard_bit` is 0 and `v2c_vld` is 0.
- R2: Op 1 (load) writes `load_val` into both the a priori register and the accumulator. A value of -128 (at the default 8-bit width) is stored as -127.
- R3: Op 2 (restart) copies the a priori register into the accumulator and leaves the a priori register unchanged.
- R4: The edge magnitude is `min2` when `prev_mag` equals `min1`. Otherwise it is `min1`.
- R5: The edge sign is `sgn_prod` XOR `prev_sgn`. A 1 makes the contribution the negated magnitude.
- R6: Op 3 (accumulate) sets the accumulator to accumulator plus contribution, clamped to the symmetric range ±(2^(LLR_W-1)-1). The accumulator never holds the most negative code.
- R7: Op 4 (emit) leaves the accumulator unchanged. One cycle later, `v2c_vld` is 1 and `v2c_sgn`/`v2c_mag` give clamp(accumulator − contribution) in sign-magnitude form: sign 1 means negative, and magnitude 0 always has sign 0.
- R8: `post_llr` shows the accumulator. `hard_bit` is 1 exactly when the accumulator is negative.
- R9: Op codes 0, 5, 6 and 7 change neither register, and `v2c_vld` is 0 in the cycle after any op other than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0 idle, 1 load, 2 restart, 3 accumulate, 4 emit, 5-7 idle |
| load_val | input | LLR_W | Extrinsic / a priori value for op 1, two's complement |
| sgn_prod | input | 1 | XOR of all signs seen by the check node |
| min1 | input | LLR_W-1 | Smallest magnitude at the check node |
| min2 | input | LLR_W-1 | Second smallest magnitude at the check node |
| prev_sgn | input | 1 | Sign of the message previously sent on this edge |
| prev_mag | input | LLR_W-1 | Magnitude of the message previously sent on this edge |
| post_llr | output | LLR_W | Accumulator value, two's complement |
| hard_bit | output | 1 | Hard decision, 1 when the accumulator is negative |
| v2c_vld | output | 1 | Outgoing message valid |
| v2c_sgn | output | 1 | Outgoing message sign |
| v2c_mag | output | LLR_W-1 | Outgoing message magnitude |

## Verification
The hardest situation to reach is the exact tie between `prev_mag` and `min1`. Random 7-bit magnitudes almost never produce it. The random stimulus therefore copies `min1` into `prev_mag` on about one edge in three, and directed cases force it with `min2` chosen far from `min1`, so a wrong pick shows clearly. Clamping is also hard to reach from random stimulus. It is driven by loading values near full scale before accumulating and emitting, including the -128 load value.

// File: rtl/vnode_pkg.sv
package vnode_pkg;
   typedef enum logic [2:0] {
      VN_IDLE    = 3'd0,
      VN_LOAD    = 3'd1,
      VN_RESTART = 3'd2,
      VN_ACCUM   = 3'd3,
      VN_EMIT    = 3'd4
   } vn_op_e;
endpackage

// File: rtl/vn_min_select.sv
// Forms the signed check-to-variable contribution of one edge.
module vn_min_select #(
   parameter int LLR_W = 8,
   localparam int MAG_W = LLR_W - 1
) (
   input  logic                    sgn_prod,
   input  logic                    prev_sgn,
   input  logic [MAG_W-1:0]        prev_mag,
   input  logic [MAG_W-1:0]        min1,
   input  logic [MAG_W-1:0]        min2,
   output logic signed [LLR_W-1:0] c2v
);
   logic [MAG_W-1:0]        sel_mag;
   logic                    edge_neg;
   logic signed [LLR_W-1:0] pos_val;

   // own previous message was the minimum -> take the runner-up
   assign sel_mag  = (prev_mag == min1) ? min2 : min1;
   assign edge_neg = sgn_prod ^ prev_sgn;
   assign pos_val  = $signed({1'b0, sel_mag});
   assign c2v      = edge_neg ? -pos_val : pos_val;
endmodule

// File: rtl/vn_sat_addsub.sv
// Adder/subtractor with symmetric clamp to +/-(2^(W-1)-1).
module vn_sat_addsub #(
   parameter int W = 8
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   input  logic                sub,
   output logic signed [W-1:0] y
);
   localparam logic signed [W:0] HI = {2'b00, {(W-1){1'b1}}};
   localparam logic signed [W:0] LO = {2'b11, {(W-2){1'b0}}, 1'b1};

   logic signed [W:0] a_x, b_x, s_x;

   always_comb begin
      a_x = {a[W-1], a};
      b_x = {b[W-1], b};
      s_x = sub ? (a_x - b_x) : (a_x + b_x);
      if (s_x > HI)      y = HI[W-1:0];
      else if (s_x < LO) y = LO[W-1:0];
      else               y = s_x[W-1:0];
   end
endmodule

// File: rtl/vn_signmag.sv
// Two's complement to sign-magnitude; input must not be the most negative code.
module vn_signmag #(
   parameter int W = 8
) (
   input  logic signed [W-1:0] val,
   output logic                sgn,
   output logic [W-2:0]        mag
);
   logic signed [W-1:0] neg_v;
   assign neg_v = -val;
   assign sgn   = val[W-1];
   assign mag   = val[W-1] ? neg_v[W-2:0] : val[W-2:0];
endmodule

// File: rtl/vnode_min_accum.sv
module vnode_min_accum
   import vnode_pkg::*;
#(
   parameter int LLR_W   = 8,
   parameter bit V2C_REG = 1'b1,
   localparam int MAG_W  = LLR_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op,
   input  logic [LLR_W-1:0] load_val,
   input  logic             sgn_prod,
   input  logic [MAG_W-1:0] min1,
   input  logic [MAG_W-1:0] min2,
   input  logic             prev_sgn,
   input  logic [MAG_W-1:0] prev_mag,
   output logic [LLR_W-1:0] post_llr,
   output logic             hard_bit,
   output logic             v2c_vld,
   output logic             v2c_sgn,
   output logic [MAG_W-1:0] v2c_mag
);
   localparam logic [LLR_W-1:0] MOST_NEG = {1'b1, {(LLR_W-1){1'b0}}};

   if (LLR_W < 3 || LLR_W > 32) begin : g_bad_width
      $error("vnode_min_accum: LLR_W must lie in 3..32");
   end

   logic signed [LLR_W-1:0] acc_q, prior_q;
   logic signed [LLR_W-1:0] c2v, acc_sum, v2c_tc, load_clip;
   logic                    sm_sgn;
   logic [MAG_W-1:0]        sm_mag;

   vn_min_select #(.LLR_W(LLR_W)) u_sel (
      .sgn_prod (sgn_prod),
      .prev_sgn (prev_sgn),
      .prev_mag (prev_mag),
      .min1     (min1),
      .min2     (min2),
      .c2v      (c2v)
   );

   vn_sat_addsub #(.W(LLR_W)) u_acc_add (
      .a   (acc_q),
      .b   (c2v),
      .sub (1'b0),
      .y   (acc_sum)
   );

   vn_sat_addsub #(.W(LLR_W)) u_ext_sub (
      .a   (acc_q),
      .b   (c2v),
      .sub (1'b1),
      .y   (v2c_tc)
   );

   // adding zero only clamps the most negative code
   vn_sat_addsub #(.W(LLR_W)) u_load_clip (
      .a   ($signed(load_val)),
      .b   ({LLR_W{1'b0}}),
      .sub (1'b0),
      .y   (load_clip)
   );

   vn_signmag #(.W(LLR_W)) u_sm (
      .val (v2c_tc),
      .sgn (sm_sgn),
      .mag (sm_mag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         prior_q <= '0;
      end else begin
         case (op)
            VN_LOAD: begin
               acc_q   <= load_clip;
               prior_q <= load_clip;
            end
            VN_RESTART: acc_q <= prior_q;
            VN_ACCUM:   acc_q <= acc_sum;
            default: ;
         endcase
      end
   end

   assign post_llr = acc_q;
   assign hard_bit = acc_q[LLR_W-1];

   if (V2C_REG) begin : g_v2c_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v2c_vld <= 1'b0;
            v2c_sgn <= 1'b0;
            v2c_mag <= '0;
         end else begin
            v2c_vld <= (op == VN_EMIT);
            if (op == VN_EMIT) begin
               v2c_sgn <= sm_sgn;
               v2c_mag <= sm_mag;
            end
         end
      end

      AST_VLD_FROM_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
         v2c_vld |-> ($past(op) == VN_EMIT)); // R7
      AST_NO_VLD_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
         (op != VN_EMIT) |=> !v2c_vld); // R9
   end else begin : g_v2c_comb
      assign v2c_vld = (op == VN_EMIT);
      assign v2c_sgn = sm_sgn;
      assign v2c_mag = sm_mag;
   end

   AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      post_llr != MOST_NEG); // R6
   AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (v2c_vld && v2c_mag == '0) |-> !v2c_sgn); // R7
   AST_EMIT_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (op == VN_EMIT) |=> $stable(post_llr)); // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (op == VN_IDLE || op > VN_EMIT) |=> $stable(post_llr)); // R9
   AST_RESTART_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
      (op == VN_RESTART) |=> $stable(prior_q)); // R3
   AST_HARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      hard_bit == ($signed(post_llr) < 0)); // R8
endmodule

// File: tb/vnode_min_accum_bench.sv
`timescale 1ns/1ps
module vnode_min_accum_bench;
   localparam int W = 8;
   localparam int M = W - 1;
   localparam int LIM = (1 << (W - 1)) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   op = 3'd0;
   logic [W-1:0] load_val = '0;
   logic         sgn_prod = 1'b0, prev_sgn = 1'b0;
   logic [M-1:0] min1 = '0, min2 = '0, prev_mag = '0;
   logic [W-1:0] post_llr;
   logic         hard_bit, v2c_vld, v2c_sgn;
   logic [M-1:0] v2c_mag;

   int checks = 0, errors = 0;
   int m_acc = 0, m_prior = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vnode_min_accum u_vnode_min_accum (
      .clk(clk), .rst_n(rst_n), .op(op), .load_val(load_val),
      .sgn_prod(sgn_prod), .min1(min1), .min2(min2),
      .prev_sgn(prev_sgn), .prev_mag(prev_mag),
      .post_llr(post_llr), .hard_bit(hard_bit), .v2c_vld(v2c_vld),
      .v2c_sgn(v2c_sgn), .v2c_mag(v2c_mag)
   );

   function automatic int clamp(int v);
      if (v > LIM) return LIM;
      if (v < -LIM) return -LIM;
      return v;
   endfunction

   function automatic int contrib(bit sp, bit ps, int pm, int m1, int m2);
      int s;
      s = (pm == m1) ? m2 : m1;      // R4
      return (sp ^ ps) ? -s : s;     // R5
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_state(string req);
      chk($signed(post_llr) == m_acc, req, $signed(post_llr), m_acc);
      chk(hard_bit == (m_acc < 0), {req, " R8 hard"}, hard_bit, m_acc < 0);
   endtask

   // drive at negedge, update model, check at following negedge
   task automatic step(int o, int lv, bit sp, int m1, int m2, bit ps, int pm);
      int c, e, exp_mag;
      bit exp_sgn;
      op = o[2:0]; load_val = lv[W-1:0]; sgn_prod = sp;
      min1 = m1[M-1:0]; min2 = m2[M-1:0]; prev_sgn = ps; prev_mag = pm[M-1:0];
      c = contrib(sp, ps, pm, m1, m2);
      e = clamp(m_acc - c);
      exp_sgn = (e < 0);
      exp_mag = exp_sgn ? -e : e;
      case (o)
         1: begin m_acc = clamp(lv); m_prior = m_acc; end
         2: m_acc = m_prior;
         3: m_acc = clamp(m_acc + c);
         default: ;
      endcase
      @(negedge clk);
      case (o)
         1: check_state("R2 load");
         2: check_state("R3 restart");
         3: check_state("R6 accumulate R4 R5");
         4: check_state("R7 emit holds");
         default: check_state("R9 idle holds");
      endcase
      if (o == 4) begin
         chk(v2c_vld == 1'b1, "R7 vld", v2c_vld, 1);
         chk(v2c_sgn == exp_sgn, "R7 sign R5", v2c_sgn, exp_sgn);
         chk(int'(v2c_mag) == exp_mag, "R7 mag R4", v2c_mag, exp_mag);
      end else begin
         chk(v2c_vld == 1'b0, "R9 vld low", v2c_vld, 0);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check_state("R1 in reset");
      chk(v2c_vld == 1'b0, "R1 vld", v2c_vld, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after reset");
      // R3: prior is zero after reset
      step(2, 0, 0, 0, 0, 0, 0);
      // R2: full-scale loads and clamp of most negative code
      step(1, 127, 0, 0, 0, 0, 0);
      step(1, -128, 0, 0, 0, 0, 0);
      // R6: negative clamp while accumulating
      step(3, 0, 1, 40, 90, 0, 5);
      // R3: restart returns prior -127
      step(3, 0, 0, 60, 70, 0, 1);
      step(2, 0, 0, 0, 0, 0, 0);
      // R4: tie selects min2; R5: sign from XOR
      step(1, 10, 0, 0, 0, 0, 0);
      step(3, 0, 0, 12, 50, 0, 12);    // +50
      step(3, 0, 1, 12, 50, 1, 12);    // signs cancel: +50
      step(3, 0, 1, 12, 50, 0, 3);     // -12
      // R6: positive clamp
      step(1, 120, 0, 0, 0, 0, 0);
      step(3, 0, 0, 100, 110, 0, 0);
      // R7: emit with clamp and zero result
      step(1, -127, 0, 0, 0, 0, 0);
      step(4, 0, 0, 100, 120, 0, 1);
      step(1, 5, 0, 0, 0, 0, 0);
      step(4, 0, 0, 5, 9, 0, 2);       // 5-5 = 0, sign 0
      step(4, 0, 1, 7, 9, 1, 7);       // tie: 5-9 = -4
      // R9: idle codes
      step(0, 99, 1, 3, 4, 0, 0);
      step(5, 99, 1, 3, 4, 0, 0);
      step(6, 99, 1, 3, 4, 0, 0);
      step(7, 99, 1, 3, 4, 0, 0);
      step(2, 0, 0, 0, 0, 0, 0);
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         int o, lv, m1, m2, pm;
         int r;
         r = $urandom_range(0, 99);
         if (r < 10) o = 1;
         else if (r < 18) o = 2;
         else if (r < 55) o = 3;
         else if (r < 90) o = 4;
         else o = $urandom_range(5, 7) % 8;
         if (r >= 95) o = 0;
         lv = $urandom_range(0, 255) - 128;
         m1 = $urandom_range(0, LIM);
         m2 = $urandom_range(m1, LIM);
         pm = ($urandom_range(0, 2) == 0) ? m1 : $urandom_range(0, LIM);
         step(o, lv, 1'($urandom_range(0, 1)), m1, m2,
              1'($urandom_range(0, 1)), pm);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule